// File: doc/BRIEF.md
# Programmable Frequency and Duty-Cycle Generator

This block turns one reference clock into a rectangular wave whose rate and high time are set separately by two 3-bit codes. A rate code picks a power-of-two prescale, from divide by 1 to divide by 128. The prescaled step advances a ten-state one-hot ring, so every output period holds ten equal steps. The wave goes high when the ring returns to its first state. It goes low again when the ring leaves the state that the duty code picks, which gives a high time from 10% to 80% in steps of 10%. A force-low input holds the output at zero for whole periods.

All logic runs on the reference clock and uses clock enables. The rate code, the duty code and the force-low input are captured only at a period boundary, so a change made in the middle of a period takes effect at the start of the next one. A synchronous active-high reset restarts the ring, clears the prescaler and captures the inputs as they stand.

The ring is a named state machine with states PH0 to PH9. Each state moves to the next one on a prescaled step (PH0→PH1 … PH8→PH9), and the WRAP transition PH9→PH0 marks the period boundary. Without a step the ring holds its state.

Top module: `decade_pulse_gen`

## Requirements
- R1: With rate code f (0 to 7), the ring advances once every 2^f reference cycles; code 0 advances it on every cycle. The output period is 10·2^f reference cycles.
- R2: With duty code d (0 to 7) and force-low clear, the output is high for (d+1)·2^f cycles of each period, i.e. (d+1)·10 percent.
- R3: The ring holds exactly one active state at all times and cycles PH0 to PH9 in order, one step per state.
- R4: The output rises only on the WRAP transition, in the cycle where PH0 becomes active.
- R5: The output falls only when the ring leaves state PHd for PHd+1, or at a boundary where force-low is captured high.
- R6: When force-low (input force_low = 1) is captured at a boundary, the output stays low for that entire period. If the set and the clear of the output fall on the same step, the clear wins.
- R7: The rate code, duty code and force-low are captured only on reset or on WRAP. A change at any other time leaves the current period unchanged.
- R8: The high fraction depends only on the duty code. Changing the rate code does not change it, and changing the duty code does not change the period.
- R9: Reset (rst = 1 at a clock edge) drives the output low, puts the ring in PH0 and clears the prescaler. After release the first period stays low, and the output first rises 10·2^f cycles after release.
- R10: With a 4 MHz reference, rate code 2 gives a 40-cycle period (100 kHz), and duty code 1 gives 8 high cycles (20%).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_sel | input | 3 | Rate code: prescale 2^freq_sel |
| duty_sel | input | 3 | Duty code: high for duty_sel+1 tenths |
| force_low | input | 1 | Hold the output low for the next captured period |
| wave_out | output | 1 | Generated rectangular wave |

## Verification
The bench goes after the ends of both codes: divide by 1, where every cycle is a step, and divide by 128 at 80% duty, where a prescaler that wraps one count early or late would skew both the period and the high time. It changes the codes in the middle of a period. A design that captures them at once would show a runt or stretched pulse instead of the old period followed by the new one. It checks that force-low gives an output that stays low, since a design where the set beats the clear would leak a one-step pulse at every boundary. It also checks the exact cycle of the first rise after reset, which shows whether reset starts the ring at PH0 and leaves the output low for the first period.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

    localparam int SEL_W   = 3;
    localparam int N_PHASE = 10;

    typedef enum logic [N_PHASE-1:0] {
        PH0 = 10'b00_0000_0001,
        PH1 = 10'b00_0000_0010,
        PH2 = 10'b00_0000_0100,
        PH3 = 10'b00_0000_1000,
        PH4 = 10'b00_0001_0000,
        PH5 = 10'b00_0010_0000,
        PH6 = 10'b00_0100_0000,
        PH7 = 10'b00_1000_0000,
        PH8 = 10'b01_0000_0000,
        PH9 = 10'b10_0000_0000
    } phase_t;

    typedef struct packed {
        logic [SEL_W-1:0] rate;
        logic [SEL_W-1:0] duty;
        logic             hold_low;
    } cfg_t;

endpackage

// File: rtl/dpg_prescaler.sv
module dpg_prescaler #(
    parameter int SEL_W = dpg_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] rate,
    output logic             step
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count is 2^rate - 1; rate 0 gives 0, so every cycle is a step.
    always_comb begin
        limit = CNT_W'((32'd1 << rate) - 32'd1);
        step  = (cnt_q == limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dpg_sequencer.sv
module dpg_sequencer
    import dpg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    output phase_t phase_q,
    output logic   wrap
);
    phase_t phase_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH0;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Next-state logic.
    always_comb begin
        phase_d = phase_q;
        if (step) begin
            unique case (phase_q)
                PH0: phase_d = PH1;
                PH1: phase_d = PH2;
                PH2: phase_d = PH3;
                PH3: phase_d = PH4;
                PH4: phase_d = PH5;
                PH5: phase_d = PH6;
                PH6: phase_d = PH7;
                PH7: phase_d = PH8;
                PH8: phase_d = PH9;
                PH9: phase_d = PH0;
                default: phase_d = PH0;
            endcase
        end
    end

    // Output: the WRAP transition marks a period boundary.
    always_comb begin
        wrap = step && (phase_q == PH9);
    end
endmodule

// File: rtl/dpg_settings.sv
module dpg_settings
    import dpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wrap,
    input  logic [SEL_W-1:0] rate_in,
    input  logic [SEL_W-1:0] duty_in,
    input  logic             hold_in,
    output cfg_t             cfg_q
);
    always_ff @(posedge clk) begin
        if (rst || wrap) begin
            cfg_q.rate     <= rate_in;
            cfg_q.duty     <= duty_in;
            cfg_q.hold_low <= hold_in;
        end
    end
endmodule

// File: rtl/dpg_out_latch.sv
module dpg_out_latch
    import dpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             wrap,
    input  logic [N_PHASE-1:0] phase,
    input  logic [SEL_W-1:0] duty,
    input  logic             hold_in,
    output logic             wave_q
);
    logic set_pulse;
    logic clr_pulse;

    always_comb begin
        set_pulse = wrap;
        // End of pulse: leaving phase d for phase d+1, or a boundary that starts a forced-low period.
        clr_pulse = (step && phase[duty]) || (wrap && hold_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_q <= 1'b0;
        end else if (clr_pulse) begin
            wave_q <= 1'b0;
        end else if (set_pulse) begin
            wave_q <= 1'b1;
        end
    end
endmodule

// File: rtl/decade_pulse_gen.sv
module decade_pulse_gen
    import dpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] freq_sel,
    input  logic [SEL_W-1:0] duty_sel,
    input  logic             force_low,
    output logic             wave_out
);
    cfg_t             cfg_q;
    phase_t           phase_q;
    logic             step;
    logic             wrap;
    logic [SEL_W-1:0] freq_q;
    logic [SEL_W-1:0] duty_q;
    logic             force_q;

    assign freq_q  = cfg_q.rate;
    assign duty_q  = cfg_q.duty;
    assign force_q = cfg_q.hold_low;

    dpg_settings u_settings (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap),
        .rate_in (freq_sel),
        .duty_in (duty_sel),
        .hold_in (force_low),
        .cfg_q   (cfg_q)
    );

    dpg_prescaler #(.SEL_W(SEL_W)) u_prescaler (
        .clk  (clk),
        .rst  (rst),
        .rate (freq_q),
        .step (step)
    );

    dpg_sequencer u_sequencer (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .phase_q (phase_q),
        .wrap    (wrap)
    );

    dpg_out_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .wrap    (wrap),
        .phase   (phase_q),
        .duty    (duty_q),
        .hold_in (force_low),
        .wave_q  (wave_out)
    );
endmodule

// File: rtl/decade_pulse_gen_chk.sv
module decade_pulse_gen_chk #(
    parameter int SEL_W   = dpg_pkg::SEL_W,
    parameter int N_PHASE = dpg_pkg::N_PHASE
) (
    input logic               clk,
    input logic               rst,
    input logic               step,
    input logic               wrap,
    input logic [N_PHASE-1:0] phase,
    input logic [SEL_W-1:0]   freq_q,
    input logic [SEL_W-1:0]   duty_q,
    input logic               force_q,
    input logic               wave_out
);
    logic [SEL_W:0] end_idx;
    assign end_idx = {1'b0, duty_q} + 1'b1;

    assert_div1_every_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        (freq_q == '0) |-> step);

    assert_ring_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(phase) == 1);

    assert_ring_order_R3: assert property (@(posedge clk) disable iff (rst)
        (step && phase[N_PHASE-1]) |=> phase[0]);

    assert_rise_at_ph0_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(wave_out) |-> phase[0]);

    assert_fall_at_end_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(wave_out) && !$past(rst)) |-> (force_q || phase[end_idx]));

    assert_forced_low_R6: assert property (@(posedge clk) disable iff (rst)
        force_q |-> !wave_out);

    assert_cfg_held_R7: assert property (@(posedge clk) disable iff (rst)
        (!wrap) |=> $stable({freq_q, duty_q, force_q}));

    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (!wave_out && phase[0]));
endmodule

bind decade_pulse_gen decade_pulse_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .wrap     (wrap),
    .phase    (phase_q),
    .freq_q   (freq_q),
    .duty_q   (duty_q),
    .force_q  (force_q),
    .wave_out (wave_out)
);

// File: tb/decade_pulse_gen_bench.sv
module decade_pulse_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 3000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] freq_sel = 3'd0;
    logic [2:0] duty_sel = 3'd0;
    logic       force_low = 1'b0;
    logic       wave_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    decade_pulse_gen u_decade_pulse_gen (
        .clk       (clk),
        .rst       (rst),
        .freq_sel  (freq_sel),
        .duty_sel  (duty_sel),
        .force_low (force_low),
        .wave_out  (wave_out)
    );

    function automatic int exp_period(int f);
        return 10 << f;
    endfunction

    function automatic int exp_high(int f, int d);
        return (d + 1) << f;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int f, input int d, input bit fl);
        @(negedge clk);
        rst = 1'b1;
        freq_sel = 3'(f);
        duty_sel = 3'(d);
        force_low = fl;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_rise(input string tag);
        logic prev;
        int n;
        prev = wave_out;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (wave_out && !prev) break;
            prev = wave_out;
            if (n > LIMIT) begin
                check(1'b0, tag, n, LIMIT);
                break;
            end
        end
    endtask

    // Called on the sample where the output has just risen.
    task automatic count_period(output int hi, output int per);
        logic prev;
        hi = 1;
        per = 1;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (wave_out && !prev) break;
            if (wave_out) hi++;
            per++;
            prev = wave_out;
            if (per > LIMIT) break;
        end
    endtask

    task automatic measure(input int f, input int d, input string tag);
        int hi;
        int per;
        wait_rise(tag);
        count_period(hi, per);
        check(per == exp_period(f), {tag, " period"}, per, exp_period(f));
        check(hi == exp_high(f, d), {tag, " high"}, hi, exp_high(f, d));
    endtask

    task automatic expect_low(input int cycles, input string tag);
        int highs;
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (wave_out) highs++;
        end
        check(highs == 0, tag, highs, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hi;
        int per;
        int bad;
        int seed;
        int f;
        int d;

        // R9: reset state and exact first rise.
        do_reset(1, 3, 1'b0);
        check(wave_out == 1'b0, "R9 reset output low", int'(wave_out), 0);
        bad = 0;
        for (int k = 1; k <= exp_period(1); k++) begin
            @(negedge clk);
            if (k < exp_period(1) && wave_out) bad++;
        end
        check(bad == 0, "R9 first period low", bad, 0);
        check(wave_out == 1'b1, "R9 R4 first rise at 10*2^f", int'(wave_out), 1);

        // R10: 4 MHz, code 2, duty 1 -> 40-cycle period, 8 high.
        do_reset(2, 1, 1'b0);
        measure(2, 1, "R10 100kHz 20pct");

        // R1 R2: divide by 1 and divide by 128 extremes.
        do_reset(0, 0, 1'b0);
        measure(0, 0, "R1 R2 div1 10pct");
        duty_sel = 3'd7;
        measure(0, 7, "R2 div1 80pct");
        freq_sel = 3'd7;
        measure(7, 7, "R1 R2 div128 80pct");
        duty_sel = 3'd0;
        measure(7, 0, "R1 R3 div128 10pct");

        // R7: change codes right after a rise; current period keeps old codes.
        do_reset(1, 2, 1'b0);
        wait_rise("R7 sync");
        duty_sel = 3'd6;
        freq_sel = 3'd3;
        count_period(hi, per);
        check(per == exp_period(1), "R7 old period kept", per, exp_period(1));
        check(hi == exp_high(1, 2), "R7 old high kept", hi, exp_high(1, 2));
        count_period(hi, per);
        check(per == exp_period(3), "R7 new period", per, exp_period(3));
        check(hi == exp_high(3, 6), "R7 new high", hi, exp_high(3, 6));

        // R8: same duty at two rates keeps 50 percent.
        duty_sel = 3'd4;
        freq_sel = 3'd0;
        wait_rise("R8 sync");
        count_period(hi, per);
        count_period(hi, per);
        check(hi * 2 == per, "R8 50pct at div1", hi, per / 2);
        freq_sel = 3'd5;
        count_period(hi, per);
        count_period(hi, per);
        check(hi * 2 == per && per == exp_period(5), "R8 50pct at div32", hi, exp_period(5) / 2);

        // R6: force low from reset, then while running, then release.
        do_reset(0, 7, 1'b1);
        expect_low(300, "R6 forced from reset");
        force_low = 1'b0;
        duty_sel = 3'd2;
        freq_sel = 3'd2;
        measure(2, 2, "R6 release restores");
        force_low = 1'b1;
        repeat (1300) @(negedge clk);
        expect_low(2600, "R6 forced while running");
        force_low = 1'b0;
        measure(2, 2, "R6 second release");

        // Constrained random configurations, fixed seed.
        seed = $urandom(32'd4242);
        for (int i = 0; i < 20; i++) begin
            f = int'($urandom_range(7, 0));
            d = int'($urandom_range(7, 0));
            freq_sel = 3'(f);
            duty_sel = 3'(d);
            measure(f, d, "R1 R2 R8 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule